// File: doc/BRIEF.md
# Serial memory write-completion poller

This block sits above a byte-level two-wire master engine. After a write to a serial memory, the memory runs an internal write cycle. During that cycle it ignores every command and does not acknowledge its device address. The worst case for this cycle is about 5 ms. The block does not wait that long. It finds the end of the internal write by sending the device address again and again until the memory answers with an acknowledge. It then carries straight on with the request it was given:

- a byte write: word address bytes, then one data byte;
- a current-address read: one byte read back.

Each request is taken in one cycle while the block is idle. The block then sends the byte engine one command at a time. Each command is a start condition, a stop condition, a byte write or a byte read. It waits for the engine's completion strobe and the acknowledge that comes with it before it sends the next command. A limit on the number of address attempts stops the loop if the memory never answers. When the request ends, the block reports whether it timed out and how many attempts it took.

Top module: `ackpoll_seq`

## Requirements
- R1: Every attempt is a start command followed by a byte write of the device byte. The device byte carries the 7-bit device address in bits 7:1 and the direction in bit 0: 0 for a write request, 1 for a read request.
- R2: If the device byte is not acknowledged and the attempt limit has not been reached, a stop command follows. After it comes a new start command and the next attempt.
- R3: Once a write request's device byte is acknowledged, the word address follows as ADDR_BYTES byte writes, most significant byte first. Then the data byte is written, then a stop command is sent, and the request ends.
- R4: Once a read request's device byte is acknowledged, one byte-read command follows, then a stop command. rd_data holds the byte the engine returned for that read.
- R5: When a request ends, poll_count gives the number of device-byte attempts it made, including the acknowledged one. The value holds until the next request ends.
- R6: Let the effective limit be poll_limit, or 1 when poll_limit is 0. When the attempt whose number equals the effective limit is not acknowledged, a stop command follows and the request ends with err_timeout set. No further start command is sent. err_timeout stays set until the next request is accepted.
- R7: cmd_valid is a one-cycle strobe. The first command (a start) comes the cycle after a request is accepted. Each later command comes the cycle after the engine's completion strobe for the previous one.
- R8: req_valid is ignored while busy is high. done pulses for one cycle in the cycle busy falls, and after that no command is sent until a new request is accepted.
- R9: After reset: busy, done, cmd_valid and err_timeout are 0 and poll_count is 0.
- R10: Command encoding on cmd_op: 0 is start, 1 is stop, 2 is byte write (the byte is on cmd_byte), 3 is byte read. eng_ack is 1 when the engine saw an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 for a current-address read, 0 for a byte write |
| req_dev | input | 7 | Device address |
| req_word | input | 8*ADDR_BYTES | Word address for a write |
| req_data | input | 8 | Data byte for a write |
| poll_limit | input | CNT_W | Maximum number of address attempts (0 is treated as 1) |
| eng_done | input | 1 | Byte engine finished the last command |
| eng_ack | input | 1 | Acknowledge seen for the last byte write |
| eng_rdata | input | 8 | Byte from the last byte-read command |
| cmd_valid | output | 1 | Command strobe to the byte engine |
| cmd_op | output | 2 | Command code (see R10) |
| cmd_byte | output | 8 | Byte for a byte-write command |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err_timeout | output | 1 | The last request ran out of attempts |
| rd_data | output | 8 | Byte read by the last successful read |
| poll_count | output | CNT_W | Attempts used by the last request |

## Verification
A command strobe is due in the cycle after acceptance, or in the cycle after the engine's completion strobe. The bench's engine model samples cmd_valid on the falling edge and answers after one to three cycles. This keeps the handshake latency varied.

The result outputs (done, err_timeout, poll_count, rd_data) are registered together on the edge that ends the final stop command. They are sampled on the falling edge where done is high. The whole command log for the request is then compared with a sequence built from the number of refusals the memory model was told to give and the effective limit.

Idle behaviour is checked a few cycles after done, and again after a request pulse that arrived while busy.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT
    } phase_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_READ,
        ST_STOP
    } step_e;

endpackage

// File: rtl/ackpoll_try_ctr.sv
// Counts device-address attempts and flags when the effective limit is used up.
module ackpoll_try_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             exhausted
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] eff_limit;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && cnt_q != TOP) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign eff_limit = (limit == '0) ? ONE : limit;
    assign count     = cnt_q;
    assign exhausted = (cnt_q >= eff_limit);

endmodule

// File: rtl/ackpoll_byte_sel.sv
// Maps the current step to a command code and the byte that goes with it.
module ackpoll_byte_sel
    import ackpoll_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int IDX_W      = 1
) (
    input  step_e                   step,
    input  logic [6:0]              dev,
    input  logic                    rd,
    input  logic [8*ADDR_BYTES-1:0] word,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              wdata,
    output bus_op_e                 op,
    output logic [7:0]              byte_out
);
    logic [7:0] addr_bytes [ADDR_BYTES];
    logic [7:0] addr_sel;

    // entry 0 is the most significant byte of the word address
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
        assign addr_bytes[g] = word[8*(ADDR_BYTES-1-g) +: 8];
    end

    always_comb begin
        addr_sel = addr_bytes[0];
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                addr_sel = addr_bytes[k];
            end
        end
    end

    always_comb begin
        op       = OP_START;
        byte_out = 8'h00;
        unique case (step)
            ST_START: op = OP_START;
            ST_DEV: begin
                op       = OP_WRITE;
                byte_out = {dev, rd};
            end
            ST_WADDR: begin
                op       = OP_WRITE;
                byte_out = addr_sel;
            end
            ST_WDATA: begin
                op       = OP_WRITE;
                byte_out = wdata;
            end
            ST_READ:  op = OP_READ;
            ST_STOP:  op = OP_STOP;
            default:  op = OP_STOP;
        endcase
    end

endmodule

// File: rtl/ackpoll_seq.sv
// Write-completion poller: retries the device address until acknowledged,
// then finishes a byte write or a current-address read.
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_read,
    input  logic [6:0]              req_dev,
    input  logic [8*ADDR_BYTES-1:0] req_word,
    input  logic [7:0]              req_data,
    input  logic [CNT_W-1:0]        poll_limit,
    input  logic                    eng_done,
    input  logic                    eng_ack,
    input  logic [7:0]              eng_rdata,
    output logic                    cmd_valid,
    output logic [1:0]              cmd_op,
    output logic [7:0]              cmd_byte,
    output logic                    busy,
    output logic                    done,
    output logic                    err_timeout,
    output logic [7:0]              rd_data,
    output logic [CNT_W-1:0]        poll_count
);
    localparam int AW    = 8 * ADDR_BYTES;
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    typedef struct packed {
        phase_e           phase;
        step_e            step;
        logic             rd;
        logic [6:0]       dev;
        logic [AW-1:0]    word;
        logic [7:0]       wdata;
        logic [IDX_W-1:0] idx;
        logic             again;
        logic             fail;
        logic             done;
        logic             err;
        logic [7:0]       rdata;
        logic [CNT_W-1:0] polls;
    } st_t;

    st_t st_d, st_q;

    logic             ctr_clear;
    logic             ctr_bump;
    logic [CNT_W-1:0] ctr_count;
    logic             ctr_exhausted;
    bus_op_e          sel_op;
    logic [7:0]       sel_byte;

    ackpoll_try_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctr_clear),
        .bump      (ctr_bump),
        .limit     (poll_limit),
        .count     (ctr_count),
        .exhausted (ctr_exhausted)
    );

    ackpoll_byte_sel #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_sel (
        .step     (st_q.step),
        .dev      (st_q.dev),
        .rd       (st_q.rd),
        .word     (st_q.word),
        .idx      (st_q.idx),
        .wdata    (st_q.wdata),
        .op       (sel_op),
        .byte_out (sel_byte)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        ctr_clear = 1'b0;
        ctr_bump  = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ISSUE;
                    st_d.step  = ST_START;
                    st_d.rd    = req_read;
                    st_d.dev   = req_dev;
                    st_d.word  = req_word;
                    st_d.wdata = req_data;
                    st_d.idx   = '0;
                    st_d.again = 1'b0;
                    st_d.fail  = 1'b0;
                    st_d.err   = 1'b0;
                    ctr_clear  = 1'b1;
                end
            end

            PH_ISSUE: begin
                st_d.phase = PH_WAIT;
                if (st_q.step == ST_DEV) begin
                    ctr_bump = 1'b1;
                end
            end

            PH_WAIT: begin
                if (eng_done) begin
                    st_d.phase = PH_ISSUE;
                    unique case (st_q.step)
                        ST_START: st_d.step = ST_DEV;
                        ST_DEV: begin
                            if (eng_ack) begin
                                st_d.step = st_q.rd ? ST_READ : ST_WADDR;
                                st_d.idx  = '0;
                            end else if (ctr_exhausted) begin
                                st_d.fail = 1'b1;
                                st_d.step = ST_STOP;
                            end else begin
                                st_d.again = 1'b1;
                                st_d.step  = ST_STOP;
                            end
                        end
                        ST_WADDR: begin
                            if (st_q.idx == IDX_LAST) begin
                                st_d.step = ST_WDATA;
                            end else begin
                                st_d.idx = st_q.idx + IDX_ONE;
                            end
                        end
                        ST_WDATA: st_d.step = ST_STOP;
                        ST_READ: begin
                            st_d.rdata = eng_rdata;
                            st_d.step  = ST_STOP;
                        end
                        ST_STOP: begin
                            if (st_q.again) begin
                                st_d.again = 1'b0;
                                st_d.step  = ST_START;
                            end else begin
                                st_d.phase = PH_IDLE;
                                st_d.done  = 1'b1;
                                st_d.err   = st_q.fail;
                                st_d.polls = ctr_count;
                            end
                        end
                        default: st_d.step = ST_STOP;
                    endcase
                end
            end

            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, step: ST_START, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid   = (st_q.phase == PH_ISSUE);
    assign cmd_op      = sel_op;
    assign cmd_byte    = sel_byte;
    assign busy        = (st_q.phase != PH_IDLE);
    assign done        = st_q.done;
    assign err_timeout = st_q.err;
    assign rd_data     = st_q.rdata;
    assign poll_count  = st_q.polls;

endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_read,
    input logic [CNT_W-1:0] poll_limit,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [7:0]       cmd_byte,
    input logic             busy,
    input logic             done,
    input logic             err_timeout,
    input logic [CNT_W-1:0] poll_count
);
    localparam logic [1:0] C_START = 2'd0;
    localparam logic [1:0] C_STOP  = 2'd1;
    localparam logic [1:0] C_WRITE = 2'd2;
    localparam logic [1:0] C_READ  = 2'd3;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [1:0] last_op_q;
    logic       kind_q;
    logic       first_q;
    logic [CNT_W-1:0] eff_limit;

    assign eff_limit = (poll_limit == '0) ? ONE : poll_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_op_q <= C_STOP;
            kind_q    <= 1'b0;
            first_q   <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                kind_q  <= req_read;
                first_q <= 1'b1;
            end else if (cmd_valid) begin
                first_q <= 1'b0;
            end
            if (cmd_valid) begin
                last_op_q <= cmd_op;
            end
        end
    end

    // R7
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R1
    dev_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && last_op_q == C_START) |-> (cmd_op == C_WRITE && cmd_byte[0] == kind_q));

    // R2
    start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == C_START) |-> (first_q || last_op_q == C_STOP));

    // R4
    read_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && last_op_q == C_READ) |-> (cmd_op == C_STOP));

    // R5
    polls_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (poll_count != '0));

    // R6
    timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_timeout) |-> (poll_count >= eff_limit));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid));

endmodule

bind ackpoll_seq ackpoll_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_read    (req_read),
    .poll_limit  (poll_limit),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_byte    (cmd_byte),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .poll_count  (poll_count)
);

// File: tb/ackpoll_seq_tb.sv
module ackpoll_seq_tb;
    localparam int ADDR_BYTES = 2;
    localparam int CNT_W      = 16;
    localparam int AW         = 8 * ADDR_BYTES;
    localparam int LOG_MAX    = 64;

    localparam logic [1:0] C_START = 2'd0;
    localparam logic [1:0] C_STOP  = 2'd1;
    localparam logic [1:0] C_WRITE = 2'd2;
    localparam logic [1:0] C_READ  = 2'd3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_read = 1'b0;
    logic [6:0]       req_dev = '0;
    logic [AW-1:0]    req_word = '0;
    logic [7:0]       req_data = '0;
    logic [CNT_W-1:0] poll_limit = '0;
    logic             eng_done = 1'b0;
    logic             eng_ack = 1'b0;
    logic [7:0]       eng_rdata = '0;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [7:0]       cmd_byte;
    logic             busy;
    logic             done;
    logic             err_timeout;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] poll_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // memory / byte-engine model state
    int         refusals_left = 0;
    logic [7:0] mem_byte = '0;
    int         lat_cnt = 0;
    logic       pend_ack = 1'b0;
    logic [1:0] prev_op = C_STOP;
    logic [1:0] log_op [LOG_MAX];
    logic [7:0] log_byte [LOG_MAX];
    int         log_n = 0;

    ackpoll_seq #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_dev(req_dev), .req_word(req_word), .req_data(req_data),
        .poll_limit(poll_limit), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .busy(busy), .done(done), .err_timeout(err_timeout),
        .rd_data(rd_data), .poll_count(poll_count)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    // byte engine and memory model, all on the falling edge
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                eng_done  = 1'b1;
                eng_ack   = pend_ack;
                eng_rdata = mem_byte;
            end
        end
        if (cmd_valid && rst_n) begin
            if (log_n < LOG_MAX) begin
                log_op[log_n]   = cmd_op;
                log_byte[log_n] = cmd_byte;
            end
            log_n++;
            pend_ack = 1'b1;
            if (cmd_op == C_WRITE && prev_op == C_START) begin
                if (refusals_left > 0) begin
                    pend_ack = 1'b0;
                    refusals_left--;
                end
            end
            prev_op = cmd_op;
            lat_cnt = 1 + int'($urandom % 3);
        end
    end

    task automatic run_txn(input bit rd, input logic [6:0] dev, input logic [AW-1:0] word,
                           input logic [7:0] data, input int refusals, input int limit,
                           input bit disturb);
        logic [1:0] e_op [LOG_MAX];
        logic [7:0] e_byte [LOG_MAX];
        int  e_n, lim, waited, bad_at;
        bit  exp_err;
        int  exp_polls;
        bit  seen_done;

        lim = (limit == 0) ? 1 : limit;
        exp_err   = (refusals >= lim);
        exp_polls = exp_err ? lim : refusals + 1;
        e_n = 0;
        for (int a = 0; a < exp_polls; a++) begin
            e_op[e_n] = C_START; e_byte[e_n] = 8'h00; e_n++;
            e_op[e_n] = C_WRITE; e_byte[e_n] = {dev, rd}; e_n++;
            if (a < exp_polls - 1 || exp_err) begin
                e_op[e_n] = C_STOP; e_byte[e_n] = 8'h00; e_n++;
            end
        end
        if (!exp_err) begin
            if (rd) begin
                e_op[e_n] = C_READ; e_byte[e_n] = 8'h00; e_n++;
            end else begin
                for (int b = ADDR_BYTES - 1; b >= 0; b--) begin
                    e_op[e_n] = C_WRITE; e_byte[e_n] = word[8*b +: 8]; e_n++;
                end
                e_op[e_n] = C_WRITE; e_byte[e_n] = data; e_n++;
            end
            e_op[e_n] = C_STOP; e_byte[e_n] = 8'h00; e_n++;
        end

        @(negedge clk);
        refusals_left = refusals;
        mem_byte      = 8'($urandom);
        log_n         = 0;
        prev_op       = C_STOP;
        req_valid     = 1'b1;
        req_read      = rd;
        req_dev       = dev;
        req_word      = word;
        req_data      = data;
        poll_limit    = CNT_W'(limit);
        @(negedge clk);
        req_valid = 1'b0;
        // R7: first command is a start in the cycle after acceptance
        check(cmd_valid && cmd_op == C_START && busy, "R7 first start",
              {cmd_valid, cmd_op}, {1'b1, C_START});

        seen_done = 1'b0;
        waited = 0;
        while (!seen_done && waited < 5000) begin
            if (disturb && waited == 3) begin
                req_valid = 1'b1;
                req_read  = ~rd;
                req_dev   = ~dev;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
            if (done) seen_done = 1'b1;
        end
        req_valid = 1'b0;
        check(seen_done && !busy, "R8 done with busy low", {seen_done, busy}, 2'b10);

        bad_at = -1;
        if (log_n != e_n) begin
            bad_at = (log_n < e_n) ? log_n : e_n;
        end
        for (int i = 0; i < e_n && i < log_n && bad_at < 0; i++) begin
            if (log_op[i] != e_op[i] || (log_op[i] == C_WRITE && log_byte[i] != e_byte[i]))
                bad_at = i;
        end
        if (bad_at < 0) begin
            check(1'b1, "R1 R2 R3 R4 command sequence", 0, 0);
        end else if (bad_at < log_n && bad_at < e_n) begin
            check(1'b0, rd ? "R1/R2/R4 command sequence" : "R1/R2/R3 command sequence",
                  {log_op[bad_at], log_byte[bad_at]}, {e_op[bad_at], e_byte[bad_at]});
        end else begin
            check(1'b0, "R2 R6 command count", log_n, e_n);
        end

        check(err_timeout == exp_err, "R6 timeout flag", err_timeout, exp_err);
        check(int'(poll_count) == exp_polls, "R5 attempt count", poll_count, exp_polls);
        if (rd && !exp_err) begin
            check(rd_data == mem_byte, "R4 read byte", rd_data, mem_byte);
        end

        // R8: idle and silent after completion
        log_n = 0;
        repeat (4) @(negedge clk);
        check(!busy && log_n == 0 && err_timeout == exp_err, "R8 idle after done",
              {busy, 8'(log_n)}, 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy,        "R9 busy",        busy, 0);
        check(!done,        "R9 done",        done, 0);
        check(!cmd_valid,   "R9 cmd_valid",   cmd_valid, 0);
        check(!err_timeout, "R9 err_timeout", err_timeout, 0);
        check(poll_count == '0, "R9 poll_count", poll_count, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !cmd_valid, "R9 idle after release", {busy, cmd_valid}, 0);

        // directed corners (R10 encoding is what the model decodes)
        run_txn(1'b0, 7'h50, 16'h1A2B, 8'hC3, 0, 8, 1'b0);  // R3 immediate ack
        run_txn(1'b1, 7'h50, 16'h0000, 8'h00, 0, 8, 1'b0);  // R4 immediate ack
        run_txn(1'b0, 7'h51, 16'hFF01, 8'h5A, 3, 8, 1'b0);  // R2 retries
        run_txn(1'b1, 7'h2C, 16'h0000, 8'h00, 4, 8, 1'b0);  // R2 R4
        run_txn(1'b0, 7'h50, 16'h0102, 8'h03, 5, 5, 1'b0);  // R6 exact limit
        run_txn(1'b1, 7'h50, 16'h0000, 8'h00, 4, 5, 1'b0);  // R6 one short of limit
        run_txn(1'b0, 7'h33, 16'hBEEF, 8'h77, 2, 0, 1'b0);  // R6 zero limit -> 1
        run_txn(1'b0, 7'h33, 16'h4455, 8'h66, 0, 0, 1'b0);  // zero limit, ack
        run_txn(1'b0, 7'h7F, 16'h1357, 8'h9B, 2, 8, 1'b1);  // R8 request while busy
        run_txn(1'b1, 7'h01, 16'h0000, 8'h00, 6, 3, 1'b1);  // R8 + R6

        // random mix
        for (int t = 0; t < 30; t++) begin
            run_txn(1'($urandom), 7'($urandom), AW'($urandom), 8'($urandom),
                    int'($urandom % 7), int'($urandom % 9), 1'($urandom % 4 == 0));
        end

        finish_run();
    end

endmodule